// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a bus-mapped watchdog for a single clock domain. A 32-bit down-counter advances once for each cycle that the tick-enable input is high. The first time the counter runs out, the block sets a pending flag, which it can present as an interrupt, and starts a fresh countdown from the load value. If software has not serviced the flag before the counter runs out a second time, the block raises a system-reset request. That request stays high until the block itself is reset.

Software services the watchdog by writing any value to the kick register. The write clears the pending flag and restarts the countdown. A key-protected lock gates every register write except writes to the lock register itself, so a runaway program cannot easily disarm the watchdog. Register access uses a simple two-phase bus:

- The setup phase has `sel` high and `enable` low.
- The access phase has `sel` and `enable` both high.
- Writes take effect at the access edge.
- Read data is registered at the setup edge and is valid throughout the access phase.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the following hold:
  - The block is locked, and the lock register (word offset 0xC00) reads 1.
  - The control register (0x008) reads 0.
  - The load register (0x000) and the count register (0x004) read 0xFFFFFFFF.
  - The pending flag, `irq_o` and `sys_rst_o` are all low.
- R2: Writing 0x1ACCE551 to the lock register unlocks the block, and the lock register then reads 0. Writing any other value locks the block, and the lock register then reads 1.
- R3: While the block is locked, writes to any offset other than 0xC00 change no register and no count.
- R4: A write to the load register stores the value and reloads the counter with it at the same edge. Any 32-bit value is accepted. The count register returns the live count.
- R5: Control bit 0 is the count/interrupt enable. When it is set, each tick decrements a nonzero count. A tick at count zero reloads the counter from the load register and sets the pending flag.
- R6: A tick at count zero while the flag is already set asserts `sys_rst_o` if control bit 1 is set. If control bit 1 is clear, that tick only reloads the counter and the flag stays set.
- R7: A write of any data to the kick register (0x00C) clears the pending flag and reloads the counter from the load register. A register write on the same edge takes priority over a tick.
- R8: The raw status register (0x010) bit 0 reads the flag. The masked status register (0x014) bit 0 reads the flag AND control bit 0. `irq_o` equals the masked flag.
- R9: With control bit 0 clear, the count and the flag hold their values.
- R10: Once `sys_rst_o` is high, it stays high regardless of register writes until the block is reset.
- R11: Starting from a clear flag, a count V, a load L, both enables set and a tick on every cycle, `sys_rst_o` rises V+L+2 ticks later. With load 0 and both enables set, it rises 2 ticks after the enables are written.
- R12: A cycle with `tick_i` low changes neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Watchdog count enable, one decrement per high cycle |
| sel_i | input | 1 | Bus select |
| enable_i | input | 1 | Bus access phase |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address; bits [1:0] are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered at the setup edge; unmapped offsets read 0 |
| irq_o | output | 1 | Interrupt: pending flag AND enable |
| sys_rst_o | output | 1 | Sticky system-reset request |

## Verification
The bench targets the edges between the two stages:

- A design that reset on the first expiry, or that ignored the rst-enable bit, would show a wrong `sys_rst_o` cycle, or a reset with bit 1 clear.
- Writes issued while locked and a lock with a non-key value probe the lock gate. A leaky gate would let control or load change.
- A kick on the same edge as an expiry shows whether the reload wins. If it did not, the flag would set spuriously.
- Load 0 exercises the forced-restart path.
- Gapped ticks and a cleared enable catch a counter that runs while it should hold.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WORD_AW = 10;
  localparam logic [WORD_AW-1:0] W_LOAD  = 10'h000;
  localparam logic [WORD_AW-1:0] W_VALUE = 10'h001;
  localparam logic [WORD_AW-1:0] W_CTRL  = 10'h002;
  localparam logic [WORD_AW-1:0] W_KICK  = 10'h003;
  localparam logic [WORD_AW-1:0] W_RAW   = 10'h004;
  localparam logic [WORD_AW-1:0] W_MASK  = 10'h005;
  localparam logic [WORD_AW-1:0] W_LOCK  = 10'h300;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          enable_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] count_i,
  input  logic          flag_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] load_o,
  output wd_ctrl_t      ctrl_o,
  output logic          reload_o,
  output logic [DW-1:0] reload_val_o,
  output logic          kick_o
);
  localparam logic [DW-1:0] LOAD_INIT = '1;

  logic [AW-3:0] word;
  logic          wr_stb, wr_ok, locked_q;
  logic          hit_load, hit_ctrl, hit_kick, hit_lock;
  logic [DW-1:0] load_q, rd_mux;
  wd_ctrl_t      ctrl_q;

  assign word     = addr_i[AW-1:2];
  assign wr_stb   = sel_i & enable_i & write_i;
  assign wr_ok    = wr_stb & ~locked_q;
  assign hit_lock = wr_stb & (word == W_LOCK[AW-3:0]);
  assign hit_load = wr_ok & (word == W_LOAD[AW-3:0]);
  assign hit_ctrl = wr_ok & (word == W_CTRL[AW-3:0]);
  assign hit_kick = wr_ok & (word == W_KICK[AW-3:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      load_q   <= LOAD_INIT;
      ctrl_q   <= '0;
    end else begin
      if (hit_lock) locked_q <= (wdata_i != UNLOCK_KEY);
      if (hit_load) load_q <= wdata_i;
      if (hit_ctrl) ctrl_q <= wd_ctrl_t'(wdata_i[1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (word == W_LOAD[AW-3:0])  rd_mux = load_q;
    else if (word == W_VALUE[AW-3:0]) rd_mux = count_i;
    else if (word == W_CTRL[AW-3:0])  rd_mux[1:0] = ctrl_q;
    else if (word == W_RAW[AW-3:0])   rd_mux[0] = flag_i;
    else if (word == W_MASK[AW-3:0])  rd_mux[0] = flag_i & ctrl_q.cnt_en;
    else if (word == W_LOCK[AW-3:0])  rd_mux[0] = locked_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                             rdata_o <= '0;
    else if (sel_i & ~enable_i & ~write_i) rdata_o <= rd_mux;
  end

  assign load_o       = load_q;
  assign ctrl_o       = ctrl_q;
  assign kick_o       = hit_kick;
  assign reload_o     = hit_load | hit_kick;
  assign reload_val_o = hit_load ? wdata_i : load_q;

  // R3: a write while locked to a non-lock offset leaves control and load unchanged
  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_stb && word != W_LOCK[AW-3:0]) |=>
      (ctrl_q == $past(ctrl_q) && load_q == $past(load_q)));

  // R2: the key unlocks
  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_lock && wdata_i == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          cnt_en_i,
  input  logic          rst_en_i,
  input  logic          reload_i,
  input  logic [DW-1:0] reload_val_i,
  input  logic [DW-1:0] load_i,
  input  logic          kick_i,
  output logic [DW-1:0] count_o,
  output logic          flag_o,
  output logic          sys_rst_o
);
  localparam logic [DW-1:0] CNT_INIT = '1;

  logic [DW-1:0] count_q;
  logic          flag_q, rst_q, step, at_zero;

  assign step    = cnt_en_i & tick_i & ~reload_i;
  assign at_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= CNT_INIT;
      flag_q  <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (reload_i) begin
        count_q <= reload_val_i;
        if (kick_i) flag_q <= 1'b0;
      end else if (step) begin
        if (at_zero) begin
          count_q <= load_i;
          if (!flag_q)       flag_q <= 1'b1;
          else if (rst_en_i) rst_q  <= 1'b1;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = count_q;
  assign flag_o    = flag_q;
  assign sys_rst_o = rst_q;

  // R10: the reset request is sticky
  assert_rst_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    rst_q |=> rst_q);

  // R6: the reset request rises only on a second expiry with the flag already set
  assert_rst_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_q) |-> $past(flag_q && rst_en_i && tick_i));

  // R9 and R12: no enable or no tick, and no reload, means the count holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ((!cnt_en_i || !tick_i) && !reload_i) |=>
      (count_q == $past(count_q) && flag_q == $past(flag_q)));

  // R5: the flag rises only on an enabled tick
  assert_flag_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(cnt_en_i && tick_i));
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          sel_i,
  input  logic          enable_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sys_rst_o
);
  logic [DW-1:0] count, load, reload_val;
  logic          flag, reload, kick;
  wd_ctrl_t      ctrl;

  wdog_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .sel_i(sel_i), .enable_i(enable_i),
    .write_i(write_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .count_i(count), .flag_i(flag), .rdata_o(rdata_o), .load_o(load),
    .ctrl_o(ctrl), .reload_o(reload), .reload_val_o(reload_val),
    .kick_o(kick)
  );

  wdog_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_en_i(ctrl.cnt_en),
    .rst_en_i(ctrl.rst_en), .reload_i(reload), .reload_val_i(reload_val),
    .load_i(load), .kick_i(kick), .count_o(count), .flag_o(flag),
    .sys_rst_o(sys_rst_o)
  );

  assign irq_o = flag & ctrl.cnt_en;

  // R8: the interrupt output is never high while the enable is clear
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.cnt_en |-> !irq_o);
endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                          A_KICK = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 0, rst = 1, tick = 1, sel = 0, en = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, srst;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  twostage_wdog u0 (.clk(clk), .rst(rst), .tick_i(tick), .sel_i(sel),
    .enable_i(en), .write_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst));

  // behavioural reference model
  logic [31:0] m_cnt, m_load, exp_rd;
  logic m_en, m_ren, m_flag, m_rst, m_locked;

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      A_LOAD: return m_load;
      A_VAL:  return m_cnt;
      A_CTRL: return {30'd0, m_ren, m_en};
      A_RAW:  return {31'd0, m_flag};
      A_MASK: return {31'd0, m_flag & m_en};
      A_LOCK: return {31'd0, m_locked};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '1; m_load = '1; m_en = 0; m_ren = 0; m_flag = 0; m_rst = 0;
      m_locked = 1; exp_rd = 0;
    end else begin
      logic oen, oren, reld;
      oen = m_en; oren = m_ren; reld = 0;
      if (sel && !en && !wr) exp_rd = mread(addr);
      if (sel && en && wr) begin
        if (addr == A_LOCK) m_locked = (wdata != KEY);
        else if (!m_locked) begin
          if (addr == A_LOAD) begin m_load = wdata; m_cnt = wdata; reld = 1; end
          if (addr == A_CTRL) begin m_en = wdata[0]; m_ren = wdata[1]; end
          if (addr == A_KICK) begin m_flag = 0; m_cnt = m_load; reld = 1; end
        end
      end
      if (!reld && oen && tick) begin
        if (m_cnt == 0) begin
          m_cnt = m_load;
          if (!m_flag) m_flag = 1; else if (oren) m_rst = 1;
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the outputs
  always @(negedge clk) if (!rst) begin
    chk("R8 irq_o", {31'd0, irq}, {31'd0, m_flag & m_en});
    chk("R6 sys_rst_o", {31'd0, srst}, {31'd0, m_rst});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = a; wdata = d;
    @(negedge clk); en = 1;
    @(negedge clk); sel = 0; en = 0; wr = 0;
  endtask

  task automatic bread(input logic [11:0] a, input string tag, output logic [31:0] d);
    @(negedge clk); sel = 1; en = 0; wr = 0; addr = a;
    @(negedge clk); en = 1;
    d = rdata;
    chk(tag, rdata, exp_rd);
    @(negedge clk); sel = 0; en = 0;
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic cycles_to_rst(input string tag, input int exp_n);
    int n = 0;
    while (!srst && n < 1000) begin @(negedge clk); n++; end
    chk(tag, n, exp_n);
  endtask

  initial begin
    logic [31:0] v, v2;
    do_reset();
    // R1 reset state
    bread(A_LOCK, "R1 lock", v);  chk("R1 lock const", v, 1);
    bread(A_LOAD, "R1 load", v);  chk("R1 load const", v, 32'hFFFFFFFF);
    bread(A_VAL,  "R1 value", v); chk("R1 value const", v, 32'hFFFFFFFF);
    bread(A_CTRL, "R1 ctrl", v);  chk("R1 ctrl const", v, 0);
    // R3 writes ignored while locked
    bwrite(A_CTRL, 3); bwrite(A_LOAD, 7);
    bread(A_CTRL, "R3 ctrl", v); chk("R3 ctrl const", v, 0);
    bread(A_LOAD, "R3 load", v); chk("R3 load const", v, 32'hFFFFFFFF);
    // R2 unlock
    bwrite(A_LOCK, KEY);
    bread(A_LOCK, "R2 unlocked", v); chk("R2 unlocked const", v, 0);
    // R4 load and live value
    bwrite(A_LOAD, 5);
    bread(A_VAL, "R4 value", v); chk("R4 value const", v, 5);
    bread(A_LOAD, "R4 load", v);
    // R5 and R8 interrupt stage only
    bwrite(A_CTRL, 1);
    repeat (9) @(negedge clk);
    bread(A_RAW, "R8 raw", v); chk("R5 flag set", v, 1);
    bread(A_MASK, "R8 masked", v);
    // R6 second expiry with rst enable clear: no reset
    repeat (14) @(negedge clk);
    chk("R6 no reset", {31'd0, srst}, 0);
    // R9 hold
    bwrite(A_CTRL, 0);
    bread(A_VAL, "R9 value", v);
    repeat (5) @(negedge clk);
    bread(A_VAL, "R9 value again", v2); chk("R9 held", v2, v);
    bread(A_RAW, "R9 raw", v); chk("R9 flag held", v, 1);
    bread(A_MASK, "R8 masked off", v); chk("R8 masked const", v, 0);
    // R7 kick
    bwrite(A_KICK, 32'hDEAD);
    bread(A_RAW, "R7 raw", v); chk("R7 flag cleared", v, 0);
    bread(A_VAL, "R7 value", v); chk("R7 reloaded", v, 5);
    // R12 gapped ticks
    bwrite(A_CTRL, 1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); tick = i[0]; end
    tick = 1;
    bread(A_VAL, "R12 value", v);
    // R11 full timing: kick with load 6, both enables
    bwrite(A_LOAD, 6); bwrite(A_CTRL, 3);
    bwrite(A_KICK, 0);
    cycles_to_rst("R11 V+L+2", 14);
    // R10 sticky
    bwrite(A_CTRL, 0); bwrite(A_KICK, 0);
    repeat (4) @(negedge clk);
    chk("R10 sticky", {31'd0, srst}, 1);
    // R11 forced restart with load 0
    do_reset();
    bwrite(A_LOCK, KEY); bwrite(A_LOAD, 0); bwrite(A_CTRL, 3);
    cycles_to_rst("R11 load zero", 2);
    // R2 re-lock with non-key value
    do_reset();
    bwrite(A_LOCK, KEY); bwrite(A_LOCK, 32'h12345678);
    bread(A_LOCK, "R2 relock", v); chk("R2 relock const", v, 1);
    bwrite(A_LOCK, KEY); bwrite(A_LOCK, 1);
    bwrite(A_CTRL, 1);
    bread(A_CTRL, "R3 after lock", v); chk("R3 after lock const", v, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule